// File: doc/BRIEF.md
# Sector Erase Accumulation Window

This block gathers the sectors named by a burst of sector-erase commands into one mask, so that a single erase run can clear several sectors at once. The first sector-erase beat opens a timing window. Each further sector-erase beat that arrives while the window is open adds its sector and starts the window over again. When the window runs out without a new beat, the collected mask is offered to the erase engine over a valid/ready handoff. A status pin stays low while the window is pending and goes high once the erase is under way.

Commands enter as a valid/ready stream of one opcode and one sector index per beat. `cmd_ready` is high in every state except while the mask is being offered. This is the only back-pressure the block applies. A beat is taken at a rising edge where `cmd_valid` and `cmd_ready` are both high. On the handoff side, `erase_valid` stays high and `erase_mask` stays frozen until `erase_ready` is seen high at a rising edge. The engine reports the end of the erase with a single-cycle `erase_done` pulse.

Any opcode other than sector-erase (0x30) or suspend (0xB0) that arrives during an operation discards that operation. The window length `WINDOW_CYC` is a parameter counted in clock cycles. A synthesis build sets it to 100 ms of clock time. Simulation uses a short value.

Top module: `sector_erase_window`

## Requirements
- R1: After reset, `cmd_ready` is 1, and `erase_valid`, `delay_done`, `erase_abort` and `erase_mask` are all 0.
- R2: When the block is idle, a beat with opcode 0x30 opens the window and sets bit `cmd_sector` of `erase_mask`. `delay_done` and `erase_valid` stay 0 while the window is open.
- R3: `erase_valid` and `delay_done` rise together at the `WINDOW_CYC`-th rising edge after the edge that accepted the last loaded sector beat. `erase_mask` is non-zero at that point.
- R4: A 0x30 beat that names a new sector and is accepted no later than `WINDOW_CYC` edges after the previous loaded beat adds its sector bit and restarts the window.
- R5: A 0x30 beat that names a sector already in the mask leaves the mask and the distinct count unchanged, but still restarts the window.
- R6: The mask never holds more than `MAX_LOAD` (default 8) distinct sectors. A 0x30 beat that names a new sector when the mask is already full is not added. Sectors may be loaded in any order.
- R7: A 0xB0 beat while the window is open ends the window at once. `erase_valid` is 1 after that same edge.
- R8: A beat whose opcode is neither 0x30 nor 0xB0 while the window is open clears the mask and returns the block to idle. No handoff follows. `erase_abort` is 1 for exactly the one cycle after the accepting edge.
- R9: While `erase_valid` is 1 and `erase_ready` is 0, `erase_valid` stays 1, `erase_mask` is stable and `cmd_ready` is 0.
- R10: After the handoff, `erase_valid` is 0, `delay_done` stays 1 and 0x30 beats are not loaded (the mask is unchanged). An `erase_done` pulse returns the block to idle with `delay_done` 0 and the mask cleared.
- R11: A beat whose opcode is neither 0x30 nor 0xB0 during the erase pulses `erase_abort`, returns the block to idle and clears `delay_done`.
- R12: When the block is idle, beats with any opcode other than 0x30 are ignored. The mask, `delay_done`, `erase_valid` and `erase_abort` all stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command beat is offered |
| cmd_ready | output | 1 | The block takes a beat this cycle; low only while the mask is being offered |
| cmd_op | input | 8 | Command opcode (0x30 sector erase, 0xB0 suspend, anything else foreign) |
| cmd_sector | input | SEC_W | Sector index carried by the beat |
| erase_valid | output | 1 | Collected mask is offered to the erase engine |
| erase_ready | input | 1 | Erase engine takes the mask |
| erase_mask | output | N_SECT | One bit per selected sector |
| erase_done | input | 1 | Erase engine has finished; one-cycle pulse |
| delay_done | output | 1 | Low while idle or while the window is pending; high from handoff until the erase ends |
| erase_abort | output | 1 | One-cycle pulse after a foreign opcode discards an operation |

## Verification
Every result falls due at a fixed edge. A mask bit, an abort pulse, the suspend handoff and the return to idle each show up one edge after the beat that causes them. Expiry shows up exactly `WINDOW_CYC` edges after the last loaded beat. The bench drives inputs on the falling edge and samples on a later falling edge, after the relevant number of rising edges has passed. Around expiry it checks both the cycle before and the cycle of the expected change. It also places a beat on the last edge that still counts as inside the window.

// File: rtl/sew_pkg.sv
package sew_pkg;
  localparam logic [7:0] OP_SECTOR  = 8'h30;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WIN   = 2'd1,
    ST_HAND  = 2'd2,
    ST_ERASE = 2'd3
  } sew_state_e;
endpackage

// File: rtl/sew_mask.sv
module sew_mask #(
  parameter int N_SECT   = 16,
  parameter int MAX_LOAD = 8,
  localparam int SEC_W   = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [SEC_W-1:0]  sector,
  output logic              accept,
  output logic [N_SECT-1:0] mask
);
  logic [N_SECT-1:0] hit;
  logic [N_SECT-1:0] mask_q;
  logic              full;

  for (genvar gi = 0; gi < N_SECT; gi++) begin : g_dec
    assign hit[gi] = (sector == SEC_W'(gi));
  end

  assign full   = ($countones(mask_q) >= MAX_LOAD);
  // a sector already present never counts against the limit
  assign accept = (|(mask_q & hit)) || !full;

  always_ff @(posedge clk) begin
    if (!rst_n)             mask_q <= '0;
    else if (clear)         mask_q <= '0;
    else if (load && accept) mask_q <= mask_q | hit;
  end

  assign mask = mask_q;

  assert_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mask_q) <= MAX_LOAD);
endmodule

// File: rtl/sew_timer.sv
module sew_timer #(
  parameter int WINDOW_CYC = 20,
  localparam int CW        = $clog2(WINDOW_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run && (cnt_q == CW'(WINDOW_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (run && !expire)   cnt_q <= cnt_q + 1'b1;
  end

  assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expire);
endmodule

// File: rtl/sew_fsm.sv
module sew_fsm
  import sew_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       beat,
  input  logic [7:0] op,
  input  logic       accept,
  input  logic       expire,
  input  logic       erase_ready,
  input  logic       erase_done,
  output logic       load,
  output logic       restart,
  output logic       run,
  output logic       clear,
  output logic       offering,
  output logic       window_open,
  output logic       started,
  output logic       abort_pulse
);
  sew_state_e state_q, state_d;
  logic       is_sect, is_susp, foreign, abort_now, abort_q;

  assign is_sect = (op == OP_SECTOR);
  assign is_susp = (op == OP_SUSPEND);
  assign foreign = !is_sect && !is_susp;

  always_comb begin
    state_d   = state_q;
    load      = 1'b0;
    clear     = 1'b0;
    abort_now = 1'b0;
    run       = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (beat && is_sect) begin
          load    = 1'b1;
          state_d = ST_WIN;
        end
      end
      ST_WIN: begin
        run = 1'b1;
        if (beat && foreign) begin
          clear     = 1'b1;
          abort_now = 1'b1;
          state_d   = ST_IDLE;
        end else if (beat && is_susp) begin
          state_d = ST_HAND;
        end else if (beat && is_sect) begin
          load = 1'b1;
          // a beat refused by the limit leaves expiry on its own course
          if (!accept && expire) state_d = ST_HAND;
        end else if (expire) begin
          state_d = ST_HAND;
        end
      end
      ST_HAND: begin
        if (erase_ready) state_d = ST_ERASE;
      end
      ST_ERASE: begin
        if (beat && foreign) begin
          clear     = 1'b1;
          abort_now = 1'b1;
          state_d   = ST_IDLE;
        end else if (erase_done) begin
          clear   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign restart = load && accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_now;
    end
  end

  assign offering    = (state_q == ST_HAND);
  assign window_open = (state_q == ST_WIN);
  assign started     = (state_q == ST_HAND) || (state_q == ST_ERASE);
  assign abort_pulse = abort_q;

  assert_abort_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q |=> !abort_q);
endmodule

// File: rtl/sector_erase_window.sv
module sector_erase_window
  import sew_pkg::*;
#(
  parameter int N_SECT     = 16,
  parameter int MAX_LOAD   = 8,
  parameter int WINDOW_CYC = 5_000_000,
  localparam int SEC_W     = $clog2(N_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [7:0]        cmd_op,
  input  logic [SEC_W-1:0]  cmd_sector,
  output logic              erase_valid,
  input  logic              erase_ready,
  output logic [N_SECT-1:0] erase_mask,
  input  logic              erase_done,
  output logic              delay_done,
  output logic              erase_abort
);
  logic beat, accept, expire, load, restart, run, clear;
  logic offering, window_open, started;

  assign cmd_ready = !offering;
  assign beat      = cmd_valid && cmd_ready;

  sew_mask #(.N_SECT(N_SECT), .MAX_LOAD(MAX_LOAD)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .load   (load),
    .sector (cmd_sector),
    .accept (accept),
    .mask   (erase_mask)
  );

  sew_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .run     (run),
    .expire  (expire)
  );

  sew_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .beat        (beat),
    .op          (cmd_op),
    .accept      (accept),
    .expire      (expire),
    .erase_ready (erase_ready),
    .erase_done  (erase_done),
    .load        (load),
    .restart     (restart),
    .run         (run),
    .clear       (clear),
    .offering    (offering),
    .window_open (window_open),
    .started     (started),
    .abort_pulse (erase_abort)
  );

  assign erase_valid = offering;
  assign delay_done  = started;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_valid && !erase_ready) |=> (erase_valid && $stable(erase_mask)));

  assert_mask_at_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_valid) |-> (erase_mask != '0));

  assert_foreign_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && window_open && (cmd_op != OP_SECTOR) && (cmd_op != OP_SUSPEND))
      |=> (erase_abort && erase_mask == '0 && !erase_valid));

  assert_clear_on_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(delay_done) |-> (erase_mask == '0));
endmodule

// File: tb/test_sector_erase_window.sv
module test_sector_erase_window;
  localparam int N_SECT = 16;
  localparam int MAXL   = 8;
  localparam int W      = 20;
  localparam int SW     = $clog2(N_SECT);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_op = 8'h00;
  logic [SW-1:0] cmd_sector = '0;
  logic erase_ready = 1'b0;
  logic erase_done = 1'b0;
  logic cmd_ready, erase_valid, delay_done, erase_abort;
  logic [N_SECT-1:0] erase_mask;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sector_erase_window #(.N_SECT(N_SECT), .MAX_LOAD(MAXL), .WINDOW_CYC(W)) i_sector_erase_window (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sector(cmd_sector), .erase_valid(erase_valid),
    .erase_ready(erase_ready), .erase_mask(erase_mask), .erase_done(erase_done),
    .delay_done(delay_done), .erase_abort(erase_abort));

  // {opcode, sector, expected mask after the beat, expected erase_valid}
  localparam logic [28:0] VEC [12] = '{
    {8'h30, 4'd3,  16'h0008, 1'b0},  // R2 open
    {8'h30, 4'd0,  16'h0009, 1'b0},  // R4
    {8'h30, 4'd15, 16'h8009, 1'b0},  // R4 any order
    {8'h30, 4'd3,  16'h8009, 1'b0},  // R5 duplicate
    {8'h30, 4'd7,  16'h8089, 1'b0},
    {8'h30, 4'd10, 16'h8489, 1'b0},
    {8'h30, 4'd12, 16'h9489, 1'b0},
    {8'h30, 4'd1,  16'h948B, 1'b0},
    {8'h30, 4'd5,  16'h94AB, 1'b0},  // eighth distinct sector
    {8'h30, 4'd9,  16'h94AB, 1'b0},  // R6 ninth refused
    {8'h30, 4'd12, 16'h94AB, 1'b0},  // R5 duplicate when full
    {8'hB0, 4'd0,  16'h94AB, 1'b1}   // R7 suspend ends window
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic send(input logic [7:0] op, input logic [SW-1:0] sec);
    cmd_valid = 1'b1; cmd_op = op; cmd_sector = sec;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 8'h00;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic take();
    erase_ready = 1'b1;
    @(negedge clk);
    erase_ready = 1'b0;
  endtask

  task automatic finish_erase();
    erase_done = 1'b1;
    @(negedge clk);
    erase_done = 1'b0;
  endtask

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(1);
    // R1 reset state
    chk("R1 cmd_ready", cmd_ready, 1);
    chk("R1 erase_valid", erase_valid, 0);
    chk("R1 delay_done", delay_done, 0);
    chk("R1 erase_abort", erase_abort, 0);
    chk("R1 erase_mask", erase_mask, 0);

    // vector walk: R2 R4 R5 R6 R7
    for (int i = 0; i < 12; i++) begin
      send(VEC[i][28:21], VEC[i][20:17]);
      chk("table R2 R4 R5 R6 R7 mask", erase_mask, VEC[i][16:1]);
      chk("table R2 R7 erase_valid", erase_valid, VEC[i][0]);
      chk("table R2 R7 delay_done", delay_done, VEC[i][0]);
    end

    // R9 handoff held under back-pressure
    wait_cyc(4);
    chk("R9 valid held", erase_valid, 1);
    chk("R9 mask stable", erase_mask, 16'h94AB);
    chk("R9 cmd_ready low", cmd_ready, 0);
    take();
    // R10 erase running
    chk("R10 valid dropped", erase_valid, 0);
    chk("R10 delay_done high", delay_done, 1);
    send(8'h30, 4'd2);
    chk("R10 late sector not loaded", erase_mask, 16'h94AB);
    chk("R10 delay_done kept", delay_done, 1);
    finish_erase();
    chk("R10 done clears delay_done", delay_done, 0);
    chk("R10 done clears mask", erase_mask, 0);

    // R3 exact expiry edge
    send(8'h30, 4'd4);
    wait_cyc(W - 1);
    chk("R2 window pending delay_done", delay_done, 0);
    chk("R3 not yet valid", erase_valid, 0);
    wait_cyc(1);
    chk("R3 valid on expiry", erase_valid, 1);
    chk("R3 delay_done on expiry", delay_done, 1);
    chk("R3 mask", erase_mask, 16'h0010);
    take(); finish_erase();

    // R5 duplicate on the last in-window edge restarts
    send(8'h30, 4'd4);
    wait_cyc(W - 1);
    send(8'h30, 4'd4);
    chk("R5 still open after boundary dup", erase_valid, 0);
    wait_cyc(W - 1);
    chk("R5 restarted window", erase_valid, 0);
    wait_cyc(1);
    chk("R5 expiry after restart", erase_valid, 1);
    chk("R5 mask", erase_mask, 16'h0010);
    take(); finish_erase();

    // R4 new sector mid-window restarts
    send(8'h30, 4'd4);
    wait_cyc(5);
    send(8'h30, 4'd6);
    wait_cyc(W - 1);
    chk("R4 restarted window", erase_valid, 0);
    wait_cyc(1);
    chk("R4 expiry after restart", erase_valid, 1);
    chk("R4 mask", erase_mask, 16'h0050);
    take(); finish_erase();

    // R8 foreign opcode in window
    send(8'h30, 4'd2);
    wait_cyc(3);
    send(8'h80, 4'd0);
    chk("R8 abort pulse", erase_abort, 1);
    chk("R8 mask cleared", erase_mask, 0);
    chk("R8 delay_done low", delay_done, 0);
    wait_cyc(1);
    chk("R8 abort one cycle", erase_abort, 0);
    wait_cyc(W + 2);
    chk("R8 no handoff", erase_valid, 0);

    // R12 idle ignores other opcodes
    send(8'h90, 4'd3);
    send(8'hB0, 4'd3);
    chk("R12 mask", erase_mask, 0);
    chk("R12 valid", erase_valid, 0);
    chk("R12 abort", erase_abort, 0);
    chk("R12 delay_done", delay_done, 0);

    // R7 then R11 foreign during erase
    send(8'h30, 4'd9);
    send(8'hB0, 4'd0);
    chk("R7 suspend handoff next edge", erase_valid, 1);
    chk("R7 mask", erase_mask, 16'h0200);
    take();
    send(8'h55, 4'd0);
    chk("R11 abort pulse", erase_abort, 1);
    chk("R11 delay_done low", delay_done, 0);
    chk("R11 mask cleared", erase_mask, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule